// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller that sits beside a successive-approximation converter. It divides the system clock into a slower conversion tick, waits for a software start or an armed external trigger, and runs a fixed budget of ticks for each channel. In the final ticks of that budget it tries one code bit per tick, most significant first, on the `dac_code` output. The analog comparator reports on `cmp_in` whether the input lies at or above the code under trial. When the last trial ends, the block stores the finished code in a per-channel result register and raises a one-cycle `done` strobe that carries the channel number.

The channel order comes from one of five modes. Single converts one channel once. Repeat converts one channel continuously. Sweep visits a group of channels starting at channel 0 and then stops. Repeat sweep 0 cycles through that group. Repeat sweep 1 inserts a priority channel between each of the other group members. Control and status pins are plain levels and pulses. Results are read back through a combinational read port, so no handshake is involved.

Top module: `adc_seq`

## Requirements
- R1: `cfg_div` codes 0,1,2,3,4,5 give one conversion tick every 1,2,3,4,6,12 clock cycles, and a conversion takes its tick budget multiplied by that ratio in clock cycles, counted from the edge that starts it to the edge that raises `done`.
- R2: The tick budget for one channel is 28 ticks at 8-bit and 33 ticks at 10-bit with `cfg_sh`=1, and 49 ticks at 8-bit and 59 ticks at 10-bit with `cfg_sh`=0.
- R3: The trials occupy the last N ticks of the budget, where N is 10 when `cfg_res10`=1 and 8 when it is 0. Each trial sets one bit, from bit N-1 down to bit 0, and keeps it when `cmp_in`=1. The stored result is therefore the largest N-bit code for which the comparator reports input >= code.
- R4: At 8-bit resolution, bits 9:8 of `dac_code` and of the stored result are zero.
- R5: With `cfg_ext`=0, a `start_set` pulse while `start_bit`=0 starts the sequence. A `start_set` pulse during a conversion does not change its timing.
- R6: With `cfg_ext`=1, `start_set` only arms the block: `start_bit` becomes 1 and `busy` stays 0. A high-to-low step on `trig_n` then starts the sequence. Falling edges that arrive while the block is not armed are ignored.
- R7: An armed falling edge during a conversion restarts the sequence from its first channel. When that edge lands on the cycle of the final trial, no result is written and no `done` is raised.
- R8: Mode 0 (single) converts channel `cfg_chan` once, then clears `busy` and `start_bit` in the cycle that `done` rises.
- R9: Mode 1 (repeat) converts `cfg_chan` again and again with `start_bit` kept at 1.
- R10: Mode 2 (sweep) converts channels 0 to G-1 in order, where G = 2*(`cfg_grp`+1), and then clears `busy` and `start_bit`.
- R11: Mode 3 (repeat sweep 0) cycles through channels 0 to G-1 until it is stopped.
- R12: Mode 4 (repeat sweep 1) starts with the priority channel `cfg_chan` and then alternates it with the other members of 0 to G-1 in ascending order, skipping the priority channel itself.
- R13: Each finished result is written to the register of its channel and can be read on `rd_data` for `rd_ch`. The `done` strobe reports that channel on `done_ch`. After reset every register reads zero and the block is idle.
- R14: A `start_clr` pulse stops the block at the next edge (`busy`=0, `start_bit`=0), and the result of the conversion in progress is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 3 | Tick divide-ratio select |
| cfg_res10 | input | 1 | 1 selects 10-bit resolution, 0 selects 8-bit |
| cfg_sh | input | 1 | Sample-and-hold budget select |
| cfg_mode | input | 3 | Channel sequencing mode (0 to 4) |
| cfg_chan | input | 3 | Single/repeat channel, or the priority channel in mode 4 |
| cfg_grp | input | 2 | Sweep group size select, G = 2*(cfg_grp+1) |
| cfg_ext | input | 1 | 1 selects the external trigger |
| start_set | input | 1 | Pulse that writes 1 to the start bit |
| start_clr | input | 1 | Pulse that writes 0 to the start bit and aborts |
| trig_n | input | 1 | External trigger, active on a falling edge |
| cmp_in | input | 1 | Comparator: 1 when input >= dac_code |
| dac_code | output | 10 | Code under trial |
| cur_ch | output | 3 | Channel being converted |
| busy | output | 1 | Conversion sequence running |
| start_bit | output | 1 | Current start bit |
| done | output | 1 | One-cycle strobe when a result is written |
| done_ch | output | 3 | Channel of the result just written |
| rd_ch | input | 3 | Result register read select |
| rd_data | output | 10 | Selected result register |

## Verification
The external retrigger and the completion of a conversion can fall on the same clock edge. In that case the restart has to win over the result write. The bench starts a conversion with a trigger edge, counts 48 further clock edges, and drops `trig_n` so that the second falling edge is seen on exactly the edge that carries the final trial. It then checks that `done` stays low on that edge, and that `done` rises one full budget later, which proves the sequence restarted from tick zero.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    MODE_SINGLE  = 3'd0,
    MODE_REPEAT  = 3'd1,
    MODE_SWEEP   = 3'd2,
    MODE_RSWEEP0 = 3'd3,
    MODE_RSWEEP1 = 3'd4
  } adc_mode_e;

  localparam int DIVW = 4;

  // Clock cycles per conversion tick for each select code.
  function automatic logic [DIVW-1:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    div_ratio = 4'd1;
      3'd1:    div_ratio = 4'd2;
      3'd2:    div_ratio = 4'd3;
      3'd3:    div_ratio = 4'd4;
      3'd4:    div_ratio = 4'd6;
      default: div_ratio = 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [2:0] div_sel,
  output logic       tick
);

  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;

  assign lim  = div_ratio(div_sel) - 4'd1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr || !run || tick) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int RW     = 10,
  parameter int RES_LO = 8,
  parameter int B_8    = 49,
  parameter int B_10   = 59,
  parameter int B_SH8  = 28,
  parameter int B_SH10 = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic          res10,
  input  logic          sh,
  input  logic          cmp,
  output logic [RW-1:0] dac_code,
  output logic          last,
  output logic [RW-1:0] result
);

  localparam int BM1  = (B_8 > B_10) ? B_8 : B_10;
  localparam int BM2  = (B_SH8 > B_SH10) ? B_SH8 : B_SH10;
  localparam int BMAX = (BM1 > BM2) ? BM1 : BM2;
  localparam int TCW  = $clog2(BMAX + 1);

  logic [TCW-1:0] tc, budget, trial_start, pos;
  logic [TCW-1:0] nb;
  logic [RW-1:0]  sar, mask, sar_next;
  logic           in_trial;

  assign nb          = res10 ? TCW'(RW) : TCW'(RES_LO);
  assign budget      = sh ? (res10 ? TCW'(B_SH10) : TCW'(B_SH8))
                          : (res10 ? TCW'(B_10)   : TCW'(B_8));
  assign trial_start = budget - nb;
  assign in_trial    = (tc >= trial_start);
  assign pos         = budget - TCW'(1) - tc;
  assign mask        = in_trial ? (RW'(1) << pos) : '0;
  assign dac_code    = sar | mask;
  assign sar_next    = (tick && in_trial && cmp) ? (sar | mask) : sar;
  assign last        = run && tick && (tc == budget - TCW'(1));
  assign result      = sar_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc  <= '0;
      sar <= '0;
    end else if (clr || !run) begin
      tc  <= '0;
      sar <= '0;
    end else if (tick) begin
      if (last) begin
        tc  <= '0;
        sar <= '0;
      end else begin
        tc  <= tc + 1'b1;
        sar <= sar_next;
      end
    end
  end

endmodule

// File: rtl/adc_chsel.sv
module adc_chsel
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           adv,
  input  adc_mode_e      mode,
  input  logic [CHW-1:0] pri,
  input  logic [1:0]     grp,
  output logic [CHW-1:0] ch,
  output logic           final_ch
);

  localparam int GSTEP = NCH / 4;

  logic [CHW:0]   gsize;
  logic [CHW-1:0] last_idx, ptr, n1, nskip;
  logic           pturn;

  assign gsize    = (CHW+1)'((32'(grp) + 32'd1) * GSTEP);
  assign last_idx = CHW'(gsize - 1'b1);

  function automatic logic [CHW-1:0] wrap_inc(input logic [CHW-1:0] x,
                                              input logic [CHW-1:0] top);
    wrap_inc = (x == top) ? '0 : x + 1'b1;
  endfunction

  assign n1    = wrap_inc(ptr, last_idx);
  assign nskip = (n1 == pri) ? wrap_inc(n1, last_idx) : n1;

  always_comb begin
    case (mode)
      MODE_SWEEP, MODE_RSWEEP0: ch = ptr;
      MODE_RSWEEP1:             ch = pturn ? pri : ptr;
      default:                  ch = pri;
    endcase
  end

  assign final_ch = (mode == MODE_SINGLE) ||
                    ((mode == MODE_SWEEP) && (ptr == last_idx)) ||
                    (mode > MODE_RSWEEP1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      pturn <= 1'b0;
    end else if (init) begin
      ptr   <= ((mode == MODE_RSWEEP1) && (pri == '0)) ? CHW'(1) : '0;
      pturn <= (mode == MODE_RSWEEP1);
    end else if (adv) begin
      case (mode)
        MODE_SWEEP, MODE_RSWEEP0: ptr <= n1;
        MODE_RSWEEP1: begin
          if (pturn) begin
            pturn <= 1'b0;
          end else begin
            pturn <= 1'b1;
            ptr   <= nskip;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adc_resbank.sv
module adc_resbank #(
  parameter int NCH = 8,
  parameter int RW  = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] wch,
  input  logic [RW-1:0]  wdata,
  input  logic [CHW-1:0] rch,
  output logic [RW-1:0]  rdata
);

  logic [RW-1:0] regs [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [RW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (we && (wch == CHW'(i)))   q <= wdata;
    end
    assign regs[i] = q;
  end

  assign rdata = regs[rch];

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int RW     = 10,
  parameter int RES_LO = 8,
  parameter int B_8    = 49,
  parameter int B_10   = 59,
  parameter int B_SH8  = 28,
  parameter int B_SH10 = 33,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cfg_div,
  input  logic           cfg_res10,
  input  logic           cfg_sh,
  input  logic [2:0]     cfg_mode,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [1:0]     cfg_grp,
  input  logic           cfg_ext,
  input  logic           start_set,
  input  logic           start_clr,
  input  logic           trig_n,
  input  logic           cmp_in,
  output logic [RW-1:0]  dac_code,
  output logic [CHW-1:0] cur_ch,
  output logic           busy,
  output logic           start_bit,
  output logic           done,
  output logic [CHW-1:0] done_ch,
  input  logic [CHW-1:0] rd_ch,
  output logic [RW-1:0]  rd_data
);

  adc_mode_e      mode;
  logic           running, start_q, trig_q, done_q;
  logic [CHW-1:0] done_ch_q, ch;
  logic           fall, go, abort_now, tick, last, accept, fin;
  logic [RW-1:0]  result;

  assign mode      = adc_mode_e'(cfg_mode);
  assign fall      = trig_q && !trig_n;
  assign abort_now = start_clr;
  // Software start only from idle; external start on any armed falling edge.
  assign go        = cfg_ext ? (fall && start_q) : (start_set && !start_q);
  // Abort and restart both take priority over a finishing conversion.
  assign accept    = last && !abort_now && !go;

  adc_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (go),
    .run     (running),
    .div_sel (cfg_div),
    .tick    (tick)
  );

  adc_sar #(
    .RW(RW), .RES_LO(RES_LO), .B_8(B_8), .B_10(B_10),
    .B_SH8(B_SH8), .B_SH10(B_SH10)
  ) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (go),
    .run      (running),
    .tick     (tick),
    .res10    (cfg_res10),
    .sh       (cfg_sh),
    .cmp      (cmp_in),
    .dac_code (dac_code),
    .last     (last),
    .result   (result)
  );

  adc_chsel #(.NCH(NCH)) u_chsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (go),
    .adv      (accept && !fin),
    .mode     (mode),
    .pri      (cfg_chan),
    .grp      (cfg_grp),
    .ch       (ch),
    .final_ch (fin)
  );

  adc_resbank #(.NCH(NCH), .RW(RW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept),
    .wch   (ch),
    .wdata (result),
    .rch   (rd_ch),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      start_q   <= 1'b0;
      trig_q    <= 1'b1;
      done_q    <= 1'b0;
      done_ch_q <= '0;
    end else begin
      trig_q <= trig_n;
      done_q <= accept;
      if (accept) done_ch_q <= ch;
      if (abort_now) begin
        running <= 1'b0;
        start_q <= 1'b0;
      end else if (go) begin
        running <= 1'b1;
        start_q <= 1'b1;
      end else if (accept && fin) begin
        running <= 1'b0;
        start_q <= 1'b0;
      end else if (start_set) begin
        start_q <= 1'b1;
      end
    end
  end

  assign cur_ch    = ch;
  assign busy      = running;
  assign start_bit = start_q;
  assign done      = done_q;
  assign done_ch   = done_ch_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NCH    = 8,
  parameter int RW     = 10,
  parameter int RES_LO = 8,
  localparam int CHW   = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_res10,
  input logic [2:0]     cfg_mode,
  input logic [1:0]     cfg_grp,
  input logic [RW-1:0]  dac_code,
  input logic [CHW-1:0] cur_ch,
  input logic           busy,
  input logic           start_bit,
  input logic           done
);

  localparam int GSTEP = NCH / 4;

  logic [CHW:0] gsize;
  assign gsize = (CHW+1)'((32'(cfg_grp) + 32'd1) * GSTEP);

  AST_BUSY_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> start_bit); // R5

  AST_LOW_RES_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_res10 |-> ((dac_code >> RES_LO) == '0)); // R4

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R13

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1

  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cfg_mode == 3'd0)) |-> (!busy && !start_bit)); // R8

  AST_SWEEP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((cfg_mode == 3'd2) || (cfg_mode == 3'd3))) |->
      ({1'b0, cur_ch} < gsize)); // R10

endmodule

bind adc_seq adc_seq_chk #(.NCH(NCH), .RW(RW), .RES_LO(RES_LO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_res10 (cfg_res10),
  .cfg_mode  (cfg_mode),
  .cfg_grp   (cfg_grp),
  .dac_code  (dac_code),
  .cur_ch    (cur_ch),
  .busy      (busy),
  .start_bit (start_bit),
  .done      (done)
);

// File: tb/adc_seq_tb.sv
module adc_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_div = '0;
  logic       cfg_res10 = 1'b0;
  logic       cfg_sh = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [2:0] cfg_chan = '0;
  logic [1:0] cfg_grp = '0;
  logic       cfg_ext = 1'b0;
  logic       start_set = 1'b0;
  logic       start_clr = 1'b0;
  logic       trig_n = 1'b1;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [2:0] cur_ch;
  logic       busy, start_bit, done;
  logic [2:0] done_ch;
  logic [2:0] rd_ch = '0;
  logic [9:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [9:0] ana [8];

  always #10 clk = ~clk;

  // Comparator model: input at or above the trial code.
  assign cmp_in = (dac_code <= ana[cur_ch]);

  adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_res10(cfg_res10),
    .cfg_sh(cfg_sh), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
    .cfg_grp(cfg_grp), .cfg_ext(cfg_ext), .start_set(start_set),
    .start_clr(start_clr), .trig_n(trig_n), .cmp_in(cmp_in),
    .dac_code(dac_code), .cur_ch(cur_ch), .busy(busy),
    .start_bit(start_bit), .done(done), .done_ch(done_ch),
    .rd_ch(rd_ch), .rd_data(rd_data)
  );

  // {div[2:0], res10, sh, chan[2:0], cycles[9:0]}
  localparam logic [17:0] VEC [7] = '{
    {3'd0, 1'b0, 1'b0, 3'd1, 10'd49},
    {3'd1, 1'b1, 1'b0, 3'd0, 10'd118},
    {3'd2, 1'b0, 1'b1, 3'd6, 10'd84},
    {3'd3, 1'b1, 1'b1, 3'd4, 10'd132},
    {3'd4, 1'b1, 1'b0, 3'd7, 10'd354},
    {3'd5, 1'b0, 1'b1, 3'd5, 10'd336},
    {3'd0, 1'b1, 1'b1, 3'd2, 10'd33}
  };

  function automatic int expv(input int ch, input bit r10);
    int v;
    v = int'(ana[ch]);
    if (!r10 && v > 255) v = 255;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); start_clr = 1'b1;
    @(negedge clk); start_clr = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_n = 1'b0;
    @(negedge clk); trig_n = 1'b1;
  endtask

  task automatic wait_done(output int k);
    bit found = 0;
    k = -1;
    for (int i = 1; i <= 4000 && !found; i++) begin
      @(posedge clk); #1;
      if (done) begin k = i; found = 1; end
    end
  endtask

  task automatic count_done(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (done) c++;
    end
  endtask

  task automatic expect_order(input string req, input int n,
                              input logic [2:0] seq [8]);
    int k;
    for (int i = 0; i < n; i++) begin
      wait_done(k);
      check(req, int'(done_ch), int'(seq[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    int k;
    int c;
    logic [2:0] seq [8];
    ana[0] = 10'h2A5; ana[1] = 10'h0F3; ana[2] = 10'h3FF; ana[3] = 10'h000;
    ana[4] = 10'h155; ana[5] = 10'h1C8; ana[6] = 10'h07E; ana[7] = 10'h301;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R13 reset busy", int'(busy), 0);
    check("R13 reset start_bit", int'(start_bit), 0);
    check("R13 reset done", int'(done), 0);
    for (int i = 0; i < 8; i++) begin
      rd_ch = 3'(i); #1;
      check("R13 reset result", int'(rd_data), 0);
    end

    // Vector walk: divider, budget, SAR value, single mode.
    for (int i = 0; i < 7; i++) begin
      logic [17:0] v;
      v = VEC[i];
      @(negedge clk);
      cfg_div = v[17:15]; cfg_res10 = v[14]; cfg_sh = v[13];
      cfg_chan = v[12:10]; cfg_mode = 3'd0; rd_ch = v[12:10];
      pulse_start();
      wait_done(k);
      check("R1 R2 conversion cycles", k, int'(v[9:0]));
      check("R13 done_ch", int'(done_ch), int'(v[12:10]));
      check("R3 R4 result", int'(rd_data), expv(int'(v[12:10]), v[14]));
      check("R8 busy cleared", int'(busy), 0);
      check("R8 start_bit cleared", int'(start_bit), 0);
    end

    // R5: start_set during a conversion leaves its timing alone.
    @(negedge clk);
    cfg_div = 3'd0; cfg_res10 = 1'b0; cfg_sh = 1'b0; cfg_chan = 3'd3;
    pulse_start();
    repeat (10) @(posedge clk);
    pulse_start();
    wait_done(k);
    check("R5 ignored restart", k, 38);

    // R10: sweep over channels 0..3, then stop.
    @(negedge clk);
    cfg_res10 = 1'b1; cfg_sh = 1'b1; cfg_mode = 3'd2; cfg_grp = 2'd1;
    pulse_start();
    seq = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0};
    expect_order("R10 sweep order", 4, seq);
    #1;
    check("R10 sweep stops", int'(busy), 0);
    check("R10 sweep clears start", int'(start_bit), 0);
    for (int i = 0; i < 4; i++) begin
      rd_ch = 3'(i); #1;
      check("R13 sweep result", int'(rd_data), expv(i, 1'b1));
    end

    // R11: repeat sweep 0 over channels 0..1.
    @(negedge clk);
    cfg_mode = 3'd3; cfg_grp = 2'd0;
    pulse_start();
    seq = '{3'd0, 3'd1, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0};
    expect_order("R11 repeat sweep order", 4, seq);
    pulse_clr();
    #1;
    check("R14 stop busy", int'(busy), 0);

    // R12: repeat sweep 1, priority channel 2, group 0..3.
    @(negedge clk);
    cfg_mode = 3'd4; cfg_grp = 2'd1; cfg_chan = 3'd2;
    pulse_start();
    seq = '{3'd2, 3'd0, 3'd2, 3'd1, 3'd2, 3'd3, 3'd2, 3'd0};
    expect_order("R12 interleave order", 8, seq);
    pulse_clr();

    // R9 and R14: repeat on channel 5, then abort mid-conversion.
    @(negedge clk);
    cfg_mode = 3'd1; cfg_chan = 3'd5;
    pulse_start();
    seq = '{3'd5, 3'd5, 3'd5, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};
    expect_order("R9 repeat channel", 3, seq);
    check("R9 start_bit held", int'(start_bit), 1);
    check("R9 still busy", int'(busy), 1);
    repeat (10) @(posedge clk);
    pulse_clr();
    #1;
    check("R14 abort busy", int'(busy), 0);
    check("R14 abort start_bit", int'(start_bit), 0);
    count_done(80, c);
    check("R14 no result after abort", c, 0);

    // External trigger, single mode, 8-bit, 49 ticks at divide 1.
    @(negedge clk);
    cfg_mode = 3'd0; cfg_res10 = 1'b0; cfg_sh = 1'b0; cfg_chan = 3'd6;
    cfg_ext = 1'b1; rd_ch = 3'd6;
    pulse_trig();
    repeat (3) @(posedge clk); #1;
    check("R6 unarmed edge ignored", int'(busy), 0);
    pulse_start();
    repeat (5) @(posedge clk); #1;
    check("R6 armed start_bit", int'(start_bit), 1);
    check("R6 armed waits", int'(busy), 0);
    pulse_trig();
    #1;
    check("R6 edge starts", int'(busy), 1);
    repeat (20) @(posedge clk);
    pulse_trig();
    wait_done(k);
    check("R7 retrigger restarts", k, 49);
    check("R3 ext result", int'(rd_data), expv(6, 1'b0));
    check("R8 ext single clears start", int'(start_bit), 0);
    pulse_trig();
    #1;
    check("R6 edge after finish ignored", int'(busy), 0);

    // R7: retrigger on the edge of the final trial.
    pulse_start();
    pulse_trig();
    repeat (48) @(posedge clk);
    @(negedge clk); trig_n = 1'b0;
    @(posedge clk); #1;
    check("R7 coincident edge no done", int'(done), 0);
    check("R7 coincident edge still busy", int'(busy), 1);
    trig_n = 1'b1;
    wait_done(k);
    check("R7 coincident edge restarts", k, 49);

    finish_run();
  end

endmodule